// File: doc/BRIEF.md
# Auto-Incrementing Indirect Word Memory Port

This block puts a 16-bit-word memory behind a small byte-wide register bus. The memory has no addresses of its own on that bus; software reaches it by first loading a word pointer through a pointer register, then moving data through data registers. After every completed word access the pointer steps by one, so a block of consecutive words can be streamed without rewriting the pointer.

Two access styles share the same memory and pointer. The split style uses a low-byte register and a high-byte register: the low byte is staged, and the access to the high byte completes the word. The paired style uses one data register that takes two bus accesses in a row, low byte first, then high byte. A byte-phase state machine with two states, PH_LOW (next paired access is the low byte) and PH_HIGH (next paired access is the high byte), tracks paired accesses. Its transitions are: PH_LOW to PH_HIGH on a paired access; PH_HIGH to PH_LOW on a paired access (which completes the word and steps the pointer); either state to PH_LOW on a pointer write.

Register indices on `bus_addr`: 0 = pointer, 1 = split low byte, 2 = split high byte, 3 = paired data.

Top module: `ind_mem_port`

## Requirements
- R1: While and after reset the pointer is 0, the byte phase is PH_LOW and `bus_rdata` is 0.
- R2: A write to register 0 loads the pointer from the low 6 bits of the write data; a read of register 0 returns the pointer zero-extended to 8 bits.
- R3: A write to register 1 only stages the low byte: the memory word at the pointer and the pointer itself are unchanged.
- R4: A write to register 2 stores {write data, staged low byte} into the word at the pointer and then increments the pointer.
- R5: A read of register 1 returns bits 7:0 of the word at the pointer and leaves the pointer unchanged; a read of register 2 returns bits 15:8 of that word and increments the pointer.
- R6: In PH_LOW a write to register 3 latches the low byte without touching memory or pointer; in PH_HIGH it stores {write data, latched low byte} at the pointer and increments the pointer.
- R7: In PH_LOW a read of register 3 returns bits 7:0 of the word at the pointer; in PH_HIGH it returns bits 15:8 and increments the pointer.
- R8: A write to register 0 returns the byte phase to PH_LOW, so an unfinished paired word is discarded.
- R9: The pointer wraps from 63 to 0 (memory depth 64 words).
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read; when write and read strobes are both high, the write is performed and the read is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_rdata | output | 8 | Registered read data |

## Verification
On every cycle the assertions check the pointer's response to each kind of access: loading on a pointer write, stepping on a high-byte or completing paired access, staying still on a split low-byte write, and the phase moving to PH_LOW on a pointer write and to PH_HIGH on a first paired access. Whether the right bytes land in the right word, the read data values of each register, the wrap at the top of memory, the discard of a half-finished paired word and the read-loses-to-write rule can only be shown by the bench's scenarios, which write words through one style and read them back through the other.

// File: rtl/imp_pkg.sv
package imp_pkg;
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    localparam logic [1:0] REG_PTR  = 2'd0;
    localparam logic [1:0] REG_LO   = 2'd1;
    localparam logic [1:0] REG_HI   = 2'd2;
    localparam logic [1:0] REG_PAIR = 2'd3;
endpackage

// File: rtl/imp_word_ram.sv
module imp_word_ram #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/imp_ctrl.sv
module imp_ctrl
    import imp_pkg::*;
#(
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             pair_tick,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output phase_e           phase
);
    phase_e           phase_q, phase_d;
    logic [PTR_W-1:0] ptr_q, ptr_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_LOW;
            ptr_q   <= '0;
        end else begin
            phase_q <= phase_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_LOW: begin
                if (!ptr_load && pair_tick) phase_d = PH_HIGH;
            end
            PH_HIGH: begin
                if (ptr_load || pair_tick) phase_d = PH_LOW;
            end
            default: phase_d = PH_LOW;
        endcase

        if (ptr_load)  ptr_d = ptr_val;
        else if (step) ptr_d = ptr_q + PTR_W'(1);
        else           ptr_d = ptr_q;
    end

    assign ptr   = ptr_q;
    assign phase = phase_q;

    assert_phase_enter_high_R6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_LOW && pair_tick && !ptr_load) |=> (phase_q == PH_HIGH));
endmodule

// File: rtl/ind_mem_port.sv
module ind_mem_port
    import imp_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam int WORD_W = 2 * DATA_W;

    logic              wr_ev, rd_ev, acc_ev;
    logic              ptr_load, pair_tick, step, mem_we;
    logic [PTR_W-1:0]  ptr;
    phase_e            phase;
    logic [DATA_W-1:0] split_lo_q, pair_lo_q, rdata_q, rdata_d;
    logic [WORD_W-1:0] word_rd, word_wr;

    assign wr_ev  = bus_wr;
    assign rd_ev  = bus_rd && !bus_wr;
    assign acc_ev = wr_ev || rd_ev;

    assign ptr_load  = wr_ev && (bus_addr == REG_PTR);
    assign pair_tick = acc_ev && (bus_addr == REG_PAIR);
    assign step      = acc_ev && ((bus_addr == REG_HI) ||
                                  ((bus_addr == REG_PAIR) && (phase == PH_HIGH)));
    assign mem_we    = wr_ev && ((bus_addr == REG_HI) ||
                                 ((bus_addr == REG_PAIR) && (phase == PH_HIGH)));
    assign word_wr   = (bus_addr == REG_HI) ? {bus_wdata, split_lo_q}
                                            : {bus_wdata, pair_lo_q};

    imp_ctrl #(.PTR_W(PTR_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ptr_load  (ptr_load),
        .ptr_val   (bus_wdata[PTR_W-1:0]),
        .pair_tick (pair_tick),
        .step      (step),
        .ptr       (ptr),
        .phase     (phase)
    );

    imp_word_ram #(.AW(PTR_W), .DW(WORD_W)) u_ram (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (word_wr),
        .rdata (word_rd)
    );

    always_comb begin
        rdata_d = rdata_q;
        if (rd_ev) begin
            unique case (bus_addr)
                REG_PTR:  rdata_d = DATA_W'(ptr);
                REG_LO:   rdata_d = word_rd[DATA_W-1:0];
                REG_HI:   rdata_d = word_rd[WORD_W-1:DATA_W];
                REG_PAIR: rdata_d = (phase == PH_LOW) ? word_rd[DATA_W-1:0]
                                                      : word_rd[WORD_W-1:DATA_W];
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q    <= '0;
            split_lo_q <= '0;
            pair_lo_q  <= '0;
        end else begin
            rdata_q <= rdata_d;
            if (wr_ev && bus_addr == REG_LO) split_lo_q <= bus_wdata;
            if (wr_ev && bus_addr == REG_PAIR && phase == PH_LOW) pair_lo_q <= bus_wdata;
        end
    end

    assign bus_rdata = rdata_q;

    assert_ptr_load_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_PTR) |=> (ptr == $past(bus_wdata[PTR_W-1:0])));

    assert_lo_keeps_ptr_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_LO) |=> $stable(ptr));

    assert_hi_steps_ptr_R4: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_addr == REG_HI) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

    assert_pair_done_steps_R7: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_addr == REG_PAIR && phase == PH_HIGH)
        |=> (ptr == PTR_W'($past(ptr) + 1'b1)) && (phase == PH_LOW));

    assert_ptr_write_phase_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_PTR) |=> (phase == PH_LOW));
endmodule

// File: tb/test_ind_mem_port.sv
module test_ind_mem_port;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ind_mem_port i_ind_mem_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R1 rdata after reset", int'(bus_rdata), 0);
        rd(2'd0, d);
        chk("R1 pointer after reset", int'(d), 0);
    endtask

    task automatic t_split();
        logic [7:0] d;
        wr(2'd0, 8'd5);
        rd(2'd0, d);  chk("R2 pointer load", int'(d), 5);
        wr(2'd1, 8'h34);
        rd(2'd0, d);  chk("R3 low write keeps pointer", int'(d), 5);
        wr(2'd2, 8'h12);
        rd(2'd0, d);  chk("R4 high write steps pointer", int'(d), 6);
        wr(2'd0, 8'd5);
        rd(2'd1, d);  chk("R5 low read value", int'(d), 8'h34);
        rd(2'd0, d);  chk("R5 low read keeps pointer", int'(d), 5);
        rd(2'd2, d);  chk("R5 high read value", int'(d), 8'h12);
        rd(2'd0, d);  chk("R5 high read steps pointer", int'(d), 6);
        // R3: staged low byte must not reach memory by itself
        wr(2'd0, 8'd7); wr(2'd3, 8'hAA); wr(2'd3, 8'hBB);
        wr(2'd0, 8'd7); wr(2'd1, 8'h11);
        rd(2'd1, d);  chk("R3 low write leaves memory", int'(d), 8'hAA);
    endtask

    task automatic t_pair();
        logic [7:0] d;
        wr(2'd0, 8'd10);
        wr(2'd3, 8'h78);
        rd(2'd0, d);  chk("R6 first paired write keeps pointer", int'(d), 10);
        wr(2'd3, 8'h56);
        rd(2'd0, d);  chk("R6 second paired write steps pointer", int'(d), 11);
        wr(2'd0, 8'd10);
        rd(2'd2, d);  chk("R6 committed high byte", int'(d), 8'h56);
        wr(2'd0, 8'd10);
        rd(2'd3, d);  chk("R7 paired read low", int'(d), 8'h78);
        rd(2'd0, d);  chk("R7 first paired read keeps pointer", int'(d), 10);
        rd(2'd3, d);  chk("R7 paired read high", int'(d), 8'h56);
        rd(2'd0, d);  chk("R7 second paired read steps pointer", int'(d), 11);
    endtask

    task automatic t_phase_reset();
        logic [7:0] d;
        wr(2'd0, 8'd20);
        wr(2'd3, 8'hCC);
        wr(2'd0, 8'd21);
        wr(2'd3, 8'h01);
        wr(2'd3, 8'h02);
        rd(2'd0, d);  chk("R8 pointer after restarted pair", int'(d), 22);
        wr(2'd0, 8'd21);
        rd(2'd1, d);  chk("R8 restarted low byte", int'(d), 8'h01);
        rd(2'd2, d);  chk("R8 restarted high byte", int'(d), 8'h02);
    endtask

    task automatic t_wrap();
        logic [7:0] d;
        wr(2'd0, 8'd63);
        wr(2'd3, 8'hEE);
        wr(2'd3, 8'hFF);
        rd(2'd0, d);  chk("R9 write wraps pointer", int'(d), 0);
        wr(2'd0, 8'd63);
        rd(2'd2, d);  chk("R9 word at top", int'(d), 8'hFF);
        rd(2'd0, d);  chk("R9 read wraps pointer", int'(d), 0);
    endtask

    task automatic t_timing();
        logic [7:0] d;
        wr(2'd0, 8'd30);
        rd(2'd0, d);
        repeat (3) @(negedge clk);
        chk("R10 read data holds", int'(bus_rdata), 30);
        wr(2'd1, 8'h21);
        @(negedge clk);
        bus_addr = 2'd2; bus_wdata = 8'h44; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R10 read ignored under write", int'(bus_rdata), 30);
        rd(2'd0, d);  chk("R10 write performed", int'(d), 31);
        wr(2'd0, 8'd30);
        rd(2'd2, d);  chk("R10 written high byte", int'(d), 8'h44);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 rdata during reset", int'(bus_rdata), 0);
        rst = 1'b0;
        t_reset();
        t_split();
        t_pair();
        t_phase_reset();
        t_wrap();
        t_timing();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule